// File: doc/BRIEF.md
# Cascade-Mode DMA Channel Arbiter

This block sits on the motherboard side of an expansion bus. It decides which external bus master may take the bus. Each of a group of DMA channels can be put in cascade mode. In that mode the channel stops generating transfers and becomes a bus-request path for a device on the expansion bus. An eligible channel is one that is in cascade mode, is not masked, and has its request raised. When such a channel asks for the bus, the arbiter raises a hold request to the CPU. It waits for the CPU's hold acknowledge, then returns the acknowledge for the winning channel. It keeps both asserted for as long as that channel holds its request.

The block also produces the bus-isolation controls that the board needs while an outside master drives the bus. The system address enable is the AND of two internal enables. Both internal enables are forced off by the master-claim line. Master-claim also turns the upper address transceiver inward. The lower address drivers are switched off whenever the CPU acknowledges a hold. A cascade channel generates no addresses and no strobes, and the ready input has no effect on it.

All outputs are registered. Each output reflects the inputs sampled at the previous rising clock edge. Reset is synchronous and active high.

Top module: `cascade_dma_arbiter`

## Requirements
- R1: In idle, an eligible request (request high, cascade bit 1, mask bit 0) sets `hold_req` to 1 at the next clock edge.
- R2: A channel acknowledge is set only at the clock edge that samples `hold_ack` = 1 while `hold_req` is already high. While waiting for `hold_ack`, every bit of `ch_ack` is 0.
- R3: At most one bit of `ch_ack` is 1 at any time. A request on a channel whose cascade bit is 0 never raises `hold_req` or `ch_ack`.
- R4: The `ready` input has no effect on any output.
- R5: While the granted channel stays eligible, `hold_req` and its `ch_ack` bit stay high. No re-arbitration happens, even when a higher-priority channel starts requesting.
- R6: When several channels are eligible in idle, the lowest-numbered one wins. Channel i maps to `ch_ack` bit i.
- R7: A channel whose mask bit is 1 is treated as not requesting.
- R8: When the selected channel stops being eligible (waiting or granted), `hold_req` and `ch_ack` both fall at the same edge. The next cycle is a forced idle clock, so `hold_req` stays 0 for at least two consecutive sampled cycles.
- R9: `sys_aen` is 1 only when both internal enables are active. The controller enable is active while a grant holds and `master_claim` is 0. The CPU-side enable is active while `hold_ack` is 1 and `master_claim` is 0. After an edge that samples `master_claim` = 1, `sys_aen` is 0.
- R10: `upper_dir_in` equals `master_claim` as sampled at the previous edge (1 = toward the motherboard).
- R11: `lower_drv_off` equals `hold_ack` as sampled at the previous edge (1 = drivers off).
- R12: Synchronous `rst` clears every output to 0 and returns the arbiter to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_req | input | NUM_CH | Per-channel bus request |
| ch_cascade | input | NUM_CH | Per-channel cascade-mode enable |
| ch_mask | input | NUM_CH | Per-channel mask (1 = ignore request) |
| hold_ack | input | 1 | CPU hold acknowledge |
| ready | input | 1 | Bus ready (no effect in cascade service) |
| master_claim | input | 1 | External master has claimed the bus |
| hold_req | output | 1 | Hold request to the CPU |
| ch_ack | output | NUM_CH | Per-channel acknowledge, one-hot or zero |
| sys_aen | output | 1 | System address enable |
| upper_dir_in | output | 1 | Upper 7 address bit transceiver points inward |
| lower_drv_off | output | 1 | Lower address drivers disabled |

## Verification
The patterns used are:
- A single cascade request, run through a full handshake. This separates the wait-for-hold phase from the grant phase.
- Overlapping requests, started both before and during a grant. These show apart fixed priority and the lack of re-arbitration.
- Masked and non-cascade requests, which must leave the outputs at idle.
- Toggles of `ready` and `master_claim` during a grant. These separate the ignored input from the isolation controls.
- A request withdrawn before `hold_ack` arrives, and a reset in mid-grant. These exercise the release path and the forced idle clock.

// File: rtl/cas_arb_pkg.sv
package cas_arb_pkg;
  typedef enum logic [1:0] {
    ARB_IDLE  = 2'd0,
    ARB_WAIT  = 2'd1,
    ARB_GRANT = 2'd2,
    ARB_GAP   = 2'd3
  } arb_state_t;
endpackage

// File: rtl/cas_prio_enc.sv
module cas_prio_enc #(
  parameter int NUM_CH = 4,
  localparam int IDXW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [NUM_CH-1:0] req,
  output logic              any,
  output logic [IDXW-1:0]   idx
);
  // lowest index wins: scan downward so the last hit is the smallest
  always_comb begin
    idx = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (req[i]) idx = IDXW'(i);
    end
  end
  assign any = |req;
endmodule

// File: rtl/cas_arb_fsm.sv
module cas_arb_fsm
  import cas_arb_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int IDXW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] elig,
  input  logic              hold_ack,
  output logic              hold_req,
  output logic [NUM_CH-1:0] ch_ack,
  output logic              grant_next
);
  arb_state_t       state_q, state_d;
  logic [IDXW-1:0]  sel_q, sel_d;
  logic             win_any;
  logic [IDXW-1:0]  win_idx;
  logic             sel_live;

  cas_prio_enc #(.NUM_CH(NUM_CH)) u_prio (
    .req (elig),
    .any (win_any),
    .idx (win_idx)
  );

  assign sel_live = elig[sel_q];

  always_comb begin
    state_d = state_q;
    sel_d   = sel_q;
    unique case (state_q)
      ARB_IDLE: if (win_any) begin
        state_d = ARB_WAIT;
        sel_d   = win_idx;
      end
      ARB_WAIT: begin
        if (!sel_live)     state_d = ARB_GAP;
        else if (hold_ack) state_d = ARB_GRANT;
      end
      ARB_GRANT: if (!sel_live) state_d = ARB_GAP;
      ARB_GAP:   state_d = ARB_IDLE;
      default:   state_d = ARB_IDLE;
    endcase
  end

  assign grant_next = (state_d == ARB_GRANT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ARB_IDLE;
      sel_q    <= '0;
      hold_req <= 1'b0;
      ch_ack   <= '0;
    end else begin
      state_q  <= state_d;
      sel_q    <= sel_d;
      hold_req <= (state_d == ARB_WAIT) || (state_d == ARB_GRANT);
      for (int i = 0; i < NUM_CH; i++) begin
        ch_ack[i] <= grant_next && (sel_d == IDXW'(i));
      end
    end
  end
endmodule

// File: rtl/cas_bus_iso.sv
module cas_bus_iso (
  input  logic clk,
  input  logic rst,
  input  logic grant_next,
  input  logic hold_ack,
  input  logic master_claim,
  output logic sys_aen,
  output logic upper_dir_in,
  output logic lower_drv_off
);
  logic aen_ctl, aen_cpu;

  // both internal enables are overridden by an external master claim
  assign aen_ctl = grant_next && !master_claim;
  assign aen_cpu = hold_ack   && !master_claim;

  always_ff @(posedge clk) begin
    if (rst) begin
      sys_aen       <= 1'b0;
      upper_dir_in  <= 1'b0;
      lower_drv_off <= 1'b0;
    end else begin
      sys_aen       <= aen_ctl && aen_cpu;
      upper_dir_in  <= master_claim;
      lower_drv_off <= hold_ack;
    end
  end
endmodule

// File: rtl/cascade_dma_arbiter.sv
module cascade_dma_arbiter #(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] ch_req,
  input  logic [NUM_CH-1:0] ch_cascade,
  input  logic [NUM_CH-1:0] ch_mask,
  input  logic              hold_ack,
  input  logic              ready,
  input  logic              master_claim,
  output logic              hold_req,
  output logic [NUM_CH-1:0] ch_ack,
  output logic              sys_aen,
  output logic              upper_dir_in,
  output logic              lower_drv_off
);
  logic [NUM_CH-1:0] elig;
  logic              grant_next;
  logic              ready_unused;

  // cascade service does not wait on bus ready
  assign ready_unused = ready;
  assign elig = ch_req & ch_cascade & ~ch_mask;

  cas_arb_fsm #(.NUM_CH(NUM_CH)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .elig       (elig),
    .hold_ack   (hold_ack),
    .hold_req   (hold_req),
    .ch_ack     (ch_ack),
    .grant_next (grant_next)
  );

  cas_bus_iso u_iso (
    .clk           (clk),
    .rst           (rst),
    .grant_next    (grant_next),
    .hold_ack      (hold_ack),
    .master_claim  (master_claim),
    .sys_aen       (sys_aen),
    .upper_dir_in  (upper_dir_in),
    .lower_drv_off (lower_drv_off)
  );
endmodule

// File: rtl/cascade_dma_arbiter_chk.sv
module cascade_dma_arbiter_chk #(
  parameter int NUM_CH = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM_CH-1:0] ch_req,
  input logic [NUM_CH-1:0] ch_cascade,
  input logic [NUM_CH-1:0] ch_mask,
  input logic              hold_ack,
  input logic              master_claim,
  input logic              hold_req,
  input logic [NUM_CH-1:0] ch_ack,
  input logic              sys_aen,
  input logic              upper_dir_in,
  input logic              lower_drv_off
);
  p_ack_onehot_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ch_ack));

  p_ack_with_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (|ch_ack) |-> hold_req);

  p_ack_rise_r2: assert property (@(posedge clk) disable iff (rst)
    (!hold_req && !(|ch_ack)) |=> !(|ch_ack));

  p_keep_grant_r5: assert property (@(posedge clk) disable iff (rst)
    (|(ch_ack & ch_req & ch_cascade & ~ch_mask)) |=> (ch_ack == $past(ch_ack)));

  p_idle_gap_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(hold_req) |=> !hold_req);

  p_claim_aen_r9: assert property (@(posedge clk) disable iff (rst)
    master_claim |=> !sys_aen);

  p_claim_dir_r10: assert property (@(posedge clk) disable iff (rst)
    master_claim |=> upper_dir_in);

  p_hold_drv_r11: assert property (@(posedge clk) disable iff (rst)
    hold_ack |=> lower_drv_off);
endmodule

bind cascade_dma_arbiter cascade_dma_arbiter_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .ch_req        (ch_req),
  .ch_cascade    (ch_cascade),
  .ch_mask       (ch_mask),
  .hold_ack      (hold_ack),
  .master_claim  (master_claim),
  .hold_req      (hold_req),
  .ch_ack        (ch_ack),
  .sys_aen       (sys_aen),
  .upper_dir_in  (upper_dir_in),
  .lower_drv_off (lower_drv_off)
);

// File: tb/cascade_dma_arbiter_tb.sv
module cascade_dma_arbiter_tb;
  localparam int N = 4;
  // row: req, cascade, mask, hold_ack, master_claim, ready | hold_req, ack, aen, dir, drv_off
  localparam int VW = 23;
  localparam int NV = 24;
  localparam logic [VW-1:0] VEC [NV] = '{
    {4'b0000,4'b1111,4'b0000,1'b0,1'b0,1'b1, 1'b0,4'b0000,1'b0,1'b0,1'b0}, // R12 idle
    {4'b0110,4'b1111,4'b0000,1'b0,1'b0,1'b1, 1'b1,4'b0000,1'b0,1'b0,1'b0}, // R1 R6
    {4'b0110,4'b1111,4'b0000,1'b0,1'b0,1'b0, 1'b1,4'b0000,1'b0,1'b0,1'b0}, // R2 wait
    {4'b0110,4'b1111,4'b0000,1'b1,1'b0,1'b1, 1'b1,4'b0010,1'b1,1'b0,1'b1}, // R2 R6 R9 R11
    {4'b0110,4'b1111,4'b0000,1'b1,1'b1,1'b1, 1'b1,4'b0010,1'b0,1'b1,1'b1}, // R9 R10
    {4'b0110,4'b1111,4'b0000,1'b1,1'b1,1'b0, 1'b1,4'b0010,1'b0,1'b1,1'b1}, // R4
    {4'b0100,4'b1111,4'b0000,1'b1,1'b0,1'b1, 1'b0,4'b0000,1'b0,1'b0,1'b1}, // R8 drop
    {4'b0100,4'b1111,4'b0000,1'b0,1'b0,1'b1, 1'b0,4'b0000,1'b0,1'b0,1'b0}, // R8 gap
    {4'b0100,4'b1111,4'b0000,1'b0,1'b0,1'b1, 1'b1,4'b0000,1'b0,1'b0,1'b0}, // R1
    {4'b0100,4'b1111,4'b0000,1'b1,1'b0,1'b1, 1'b1,4'b0100,1'b1,1'b0,1'b1}, // R2
    {4'b0101,4'b1111,4'b0000,1'b1,1'b0,1'b1, 1'b1,4'b0100,1'b1,1'b0,1'b1}, // R5
    {4'b0001,4'b1111,4'b0000,1'b1,1'b0,1'b1, 1'b0,4'b0000,1'b0,1'b0,1'b1}, // R8
    {4'b0001,4'b1111,4'b0000,1'b0,1'b0,1'b1, 1'b0,4'b0000,1'b0,1'b0,1'b0}, // R8
    {4'b0001,4'b1111,4'b0000,1'b0,1'b0,1'b1, 1'b1,4'b0000,1'b0,1'b0,1'b0}, // R1
    {4'b0001,4'b1111,4'b0000,1'b1,1'b0,1'b1, 1'b1,4'b0001,1'b1,1'b0,1'b1}, // R6
    {4'b0000,4'b1111,4'b0000,1'b1,1'b0,1'b1, 1'b0,4'b0000,1'b0,1'b0,1'b1}, // R8
    {4'b0000,4'b1111,4'b0000,1'b0,1'b0,1'b1, 1'b0,4'b0000,1'b0,1'b0,1'b0}, // R8
    {4'b0011,4'b1111,4'b0001,1'b0,1'b0,1'b1, 1'b1,4'b0000,1'b0,1'b0,1'b0}, // R7
    {4'b0011,4'b1111,4'b0001,1'b1,1'b0,1'b1, 1'b1,4'b0010,1'b1,1'b0,1'b1}, // R7
    {4'b0000,4'b1111,4'b0000,1'b1,1'b0,1'b1, 1'b0,4'b0000,1'b0,1'b0,1'b1}, // R8
    {4'b0000,4'b1111,4'b0000,1'b0,1'b0,1'b1, 1'b0,4'b0000,1'b0,1'b0,1'b0}, // R8
    {4'b0001,4'b1110,4'b0000,1'b0,1'b0,1'b1, 1'b0,4'b0000,1'b0,1'b0,1'b0}, // R3
    {4'b0001,4'b1110,4'b0000,1'b1,1'b0,1'b1, 1'b0,4'b0000,1'b0,1'b0,1'b1}, // R3
    {4'b0000,4'b1111,4'b0000,1'b0,1'b1,1'b1, 1'b0,4'b0000,1'b0,1'b1,1'b0}  // R10
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] ch_req = '0, ch_cascade = '1, ch_mask = '0;
  logic         hold_ack = 1'b0, ready = 1'b1, master_claim = 1'b0;
  logic         hold_req, sys_aen, upper_dir_in, lower_drv_off;
  logic [N-1:0] ch_ack;
  int           n_run = 0, n_fail = 0;
  bit           done = 1'b0;

  always #2 clk = ~clk;

  cascade_dma_arbiter #(.NUM_CH(N)) u_dut (
    .clk(clk), .rst(rst), .ch_req(ch_req), .ch_cascade(ch_cascade),
    .ch_mask(ch_mask), .hold_ack(hold_ack), .ready(ready),
    .master_claim(master_claim), .hold_req(hold_req), .ch_ack(ch_ack),
    .sys_aen(sys_aen), .upper_dir_in(upper_dir_in), .lower_drv_off(lower_drv_off)
  );

  task automatic check(input string req_tag, input logic [7:0] exp);
    logic [7:0] act;
    act = {hold_req, ch_ack, sys_aen, upper_dir_in, lower_drv_off};
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {hold,ack,aen,dir,off} actual %b expected %b", req_tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R12 reset", 8'b0);
    @(negedge clk) rst = 1'b0;
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      {ch_req, ch_cascade, ch_mask, hold_ack, master_claim, ready} = VEC[v][22:8];
      step();
      check($sformatf("R%0s vec %0d", "1-12", v), VEC[v][7:0]);
    end
    // withdraw before hold acknowledge: R8
    @(negedge clk); {ch_req, hold_ack, master_claim} = {4'b1000, 1'b0, 1'b0};
    step(); check("R1 wait", 8'b1_0000_000);
    @(negedge clk); ch_req = 4'b0000;
    step(); check("R8 withdraw in wait", 8'b0);
    @(negedge clk); ch_req = 4'b1000;
    step(); check("R8 forced idle", 8'b0);
    step(); check("R1 re-request", 8'b1_0000_000);
    @(negedge clk); hold_ack = 1'b1;
    step(); check("R2 grant ch3", 8'b1_1000_101);
    // ready toggling during grant: R4
    @(negedge clk); ready = 1'b0;
    step(); check("R4 ready low", 8'b1_1000_101);
    // reset in mid-grant: R12
    @(negedge clk); rst = 1'b1;
    step(); check("R12 reset mid-grant", 8'b0);
    @(negedge clk); rst = 1'b0; {ch_req, hold_ack} = {4'b0000, 1'b0};
    step(); check("R12 after reset", 8'b0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (2000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule